// File: doc/BRIEF.md
# IP Header Exception Checker

This block watches a received packet as it streams in one byte per accepted cycle and classifies its network-layer header. The first byte of each packet is marked with a start flag, and on that same byte the caller gives the byte position where the layer-3 header begins. Every byte before that position is link-layer framing and is skipped.

From the layer-3 bytes the block works out which IP version is present. It checks that the header and the whole datagram are complete, verifies the IPv4 header checksum, and looks at the TTL or hop limit and at options or early extension headers. When the end-of-packet byte has been taken, the block gives a single 3-bit exception code with a one-cycle strobe. Downstream steering logic uses that code to decide whether the packet goes on the fast path or to an exception handler.

Top module: `ipx_check`

## Requirements
- R1: A well-formed IPv4 header (IHL = 5, correct checksum, nonzero TTL) or IPv6 header (nonzero hop limit, next header not an early extension), with at least as many layer-3 bytes as the declared length, gives code 0.
- R2: If the high nibble of the first layer-3 byte is neither 4 nor 6, the code is 1 and no other check affects the result.
- R3: For IPv4, the ones-complement sum of the big-endian 16-bit words over the first IHL*4 header bytes must equal 0xFFFF. Otherwise the code is 2. This check applies only when the whole header has arrived.
- R4: The code is 3 in any of these cases: the packet ends before the first layer-3 byte; IPv4 IHL (low nibble of byte 0) is below 5; fewer than IHL*4 IPv4 header bytes arrive; fewer than 40 IPv6 header bytes arrive.
- R5: The code is 4 when fewer layer-3 bytes arrive than the declared length. For IPv4 that length is the 16-bit total length in header bytes 2 and 3. For IPv6 it is 40 plus the payload length in header bytes 4 and 5. Extra trailing bytes are accepted.
- R6: The code is 5 when IPv4 TTL (header byte 8) or IPv6 hop limit (header byte 7) is zero.
- R7: The code is 6 when IPv4 IHL exceeds 5, or when the IPv6 next-header value (header byte 6) is 0, 43, 44 or 60.
- R8: When several of codes 2 to 6 apply, the lowest-numbered one is reported.
- R9: Bytes before the layer-3 offset do not affect the result. The offset is taken only on the start byte. Cycles with in_valid low change nothing, whatever the other inputs carry.
- R10: exc_valid is high for exactly the one cycle after the end-of-packet byte is accepted, and exc_code is valid in that cycle. After reset, exc_valid and exc_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A packet byte is present this cycle |
| in_sop | input | 1 | This byte is the first byte of a packet |
| in_eop | input | 1 | This byte is the last byte of a packet |
| in_data | input | 8 | Packet byte |
| l3_offset | input | OFF_W | Position of the first layer-3 byte, counted from the start byte as 0; used on the start byte only |
| exc_valid | output | 1 | One-cycle strobe carrying the verdict of the packet just ended |
| exc_code | output | 3 | Exception code, 0 to 6 |

## Verification
The bench aims at packets that end exactly at the header boundary or one byte short of it. A design that counts the first layer-3 byte wrongly would report 3 or 4 on a complete header, or 0 on a truncated one. It combines a corrupted checksum with a zero TTL and with truncation, to catch priority encoders that let a later code win, or that raise a checksum error on a header that never finished arriving. It uses nonzero offsets with prefixes that look like a version nibble, and idle cycles carrying stray start and end flags, so that a design decoding the wrong byte, or reacting to bytes with in_valid low, gives the wrong code or a spurious strobe. IPv6 next-header values on both sides of the extension set and IHL values of 4, 5 and 6 exercise the edges of the option and length decoding.

// File: rtl/ipx_pkg.sv
package ipx_pkg;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_V4    = 2'd1,
        K_V6    = 2'd2,
        K_OTHER = 2'd3
    } ipx_kind_e;

    typedef enum logic [2:0] {
        EXC_NONE      = 3'd0,
        EXC_NOT_IP    = 3'd1,
        EXC_CSUM      = 3'd2,
        EXC_HDR_SHORT = 3'd3,
        EXC_PKT_SHORT = 3'd4,
        EXC_HOP_ZERO  = 3'd5,
        EXC_OPTS      = 3'd6
    } ipx_exc_e;

    localparam int V6_HDR_BYTES = 40;
    localparam int V4_MIN_IHL   = 5;

endpackage

// File: rtl/ipx_pos_track.sv
module ipx_pos_track #(
    parameter int CNT_W = 17,
    parameter int OFF_W = 8
) (
    input  logic             in_sop,
    input  logic [OFF_W-1:0] l3_offset,
    input  logic [CNT_W-1:0] pos_q,
    input  logic [OFF_W-1:0] off_q,
    output logic [CNT_W-1:0] pos_nx,
    output logic [OFF_W-1:0] off_cur,
    output logic             in_l3,
    output logic [CNT_W-1:0] hidx
);
    logic [CNT_W-1:0] cur_pos;

    always_comb begin
        cur_pos = in_sop ? '0 : pos_q;
        off_cur = in_sop ? l3_offset : off_q;
        in_l3   = (cur_pos >= CNT_W'(off_cur));
        hidx    = cur_pos - CNT_W'(off_cur);
        // position saturates so very long packets cannot wrap back into the header
        pos_nx  = (cur_pos == '1) ? cur_pos : cur_pos + 1'b1;
    end
endmodule

// File: rtl/ipx_ones_add.sv
module ipx_ones_add (
    input  logic [15:0] a,
    input  logic [15:0] b,
    output logic [15:0] y
);
    logic [16:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        // end-around carry; raw tops out at 0x1FFFE so one fold is enough
        y   = raw[15:0] + {15'd0, raw[16]};
    end
endmodule

// File: rtl/ipx_verdict.sv
module ipx_verdict #(
    parameter int CNT_W = 17
) (
    input  ipx_pkg::ipx_kind_e kind,
    input  logic [3:0]         ihl,
    input  logic [15:0]        len_field,
    input  logic [CNT_W-1:0]   l3_cnt,
    input  logic [15:0]        csum,
    input  logic               hop_zero,
    input  logic [7:0]         nh,
    output ipx_pkg::ipx_exc_e  code
);
    import ipx_pkg::*;

    localparam int CW = (CNT_W > 17) ? CNT_W : 17;

    logic [CW-1:0] cnt_w;
    logic [CW-1:0] hdr_need;
    logic [CW-1:0] pkt_need;
    logic          hdr_short;
    logic          pkt_short;
    logic          csum_bad;
    logic          opt_seen;

    always_comb begin
        cnt_w     = CW'(l3_cnt);
        hdr_need  = '0;
        pkt_need  = '0;
        hdr_short = 1'b0;
        csum_bad  = 1'b0;
        opt_seen  = 1'b0;
        case (kind)
            K_V4: begin
                hdr_need  = CW'({ihl, 2'b00});
                pkt_need  = CW'(len_field);
                hdr_short = (ihl < 4'(V4_MIN_IHL)) || (cnt_w < hdr_need);
                csum_bad  = !hdr_short && (csum != 16'hFFFF);
                opt_seen  = (ihl > 4'(V4_MIN_IHL));
            end
            K_V6: begin
                hdr_need  = CW'(V6_HDR_BYTES);
                pkt_need  = CW'(len_field) + CW'(V6_HDR_BYTES);
                hdr_short = (cnt_w < hdr_need);
                opt_seen  = (nh == 8'd0) || (nh == 8'd43) || (nh == 8'd44) || (nh == 8'd60);
            end
            default: ;
        endcase
        pkt_short = (cnt_w < pkt_need);

        if (kind == K_NONE)       code = EXC_HDR_SHORT;
        else if (kind == K_OTHER) code = EXC_NOT_IP;
        else if (csum_bad)        code = EXC_CSUM;
        else if (hdr_short)       code = EXC_HDR_SHORT;
        else if (pkt_short)       code = EXC_PKT_SHORT;
        else if (hop_zero)        code = EXC_HOP_ZERO;
        else if (opt_seen)        code = EXC_OPTS;
        else                      code = EXC_NONE;
    end
endmodule

// File: rtl/ipx_check.sv
module ipx_check #(
    parameter int CNT_W = 17,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    input  logic [OFF_W-1:0] l3_offset,
    output logic             exc_valid,
    output logic [2:0]       exc_code
);
    import ipx_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [OFF_W-1:0] off;
        logic [CNT_W-1:0] l3_cnt;
        ipx_kind_e        kind;
        logic [3:0]       ihl;
        logic [15:0]      len_field;
        logic [7:0]       nh;
        logic             hop_zero;
        logic [7:0]       hi;
        logic [15:0]      csum;
    } fld_t;

    typedef struct packed {
        fld_t     fld;
        logic     out_valid;
        ipx_exc_e out_code;
    } st_t;

    st_t  st_q, st_d;
    fld_t fld_nx;

    logic [CNT_W-1:0] pos_nx;
    logic [OFF_W-1:0] off_cur;
    logic             in_l3;
    logic [CNT_W-1:0] hidx;
    logic [15:0]      csum_base;
    logic [15:0]      csum_sum;
    ipx_exc_e         code_nx;

    ipx_pos_track #(.CNT_W(CNT_W), .OFF_W(OFF_W)) trk_i (
        .in_sop   (in_sop),
        .l3_offset(l3_offset),
        .pos_q    (st_q.fld.pos),
        .off_q    (st_q.fld.off),
        .pos_nx   (pos_nx),
        .off_cur  (off_cur),
        .in_l3    (in_l3),
        .hidx     (hidx)
    );

    assign csum_base = in_sop ? 16'd0 : st_q.fld.csum;

    ipx_ones_add add_i (
        .a(csum_base),
        .b({st_q.fld.hi, in_data}),
        .y(csum_sum)
    );

    // next field state
    always_comb begin
        fld_nx = st_q.fld;
        if (in_valid) begin
            if (in_sop) begin
                fld_nx.l3_cnt    = '0;
                fld_nx.kind      = K_NONE;
                fld_nx.ihl       = '0;
                fld_nx.len_field = '0;
                fld_nx.nh        = '0;
                fld_nx.hop_zero  = 1'b0;
                fld_nx.hi        = '0;
                fld_nx.csum      = '0;
            end
            fld_nx.pos = pos_nx;
            fld_nx.off = off_cur;
            if (in_l3) begin
                fld_nx.l3_cnt = (hidx == '1) ? hidx : hidx + 1'b1;
                if (hidx == '0) begin
                    fld_nx.ihl = in_data[3:0];
                    case (in_data[7:4])
                        4'd4:    fld_nx.kind = K_V4;
                        4'd6:    fld_nx.kind = K_V6;
                        default: fld_nx.kind = K_OTHER;
                    endcase
                end else if (fld_nx.kind == K_V4) begin
                    if (hidx == CNT_W'(2)) fld_nx.len_field[15:8] = in_data;
                    if (hidx == CNT_W'(3)) fld_nx.len_field[7:0]  = in_data;
                    if (hidx == CNT_W'(8)) fld_nx.hop_zero        = (in_data == 8'd0);
                end else if (fld_nx.kind == K_V6) begin
                    if (hidx == CNT_W'(4)) fld_nx.len_field[15:8] = in_data;
                    if (hidx == CNT_W'(5)) fld_nx.len_field[7:0]  = in_data;
                    if (hidx == CNT_W'(6)) fld_nx.nh              = in_data;
                    if (hidx == CNT_W'(7)) fld_nx.hop_zero        = (in_data == 8'd0);
                end
                // even header bytes are word high halves; odd bytes close a word
                if (!hidx[0]) begin
                    fld_nx.hi = in_data;
                end else if (fld_nx.kind == K_V4 && hidx < CNT_W'({fld_nx.ihl, 2'b00})) begin
                    fld_nx.csum = csum_sum;
                end
            end
        end
    end

    ipx_verdict #(.CNT_W(CNT_W)) vrd_i (
        .kind     (fld_nx.kind),
        .ihl      (fld_nx.ihl),
        .len_field(fld_nx.len_field),
        .l3_cnt   (fld_nx.l3_cnt),
        .csum     (fld_nx.csum),
        .hop_zero (fld_nx.hop_zero),
        .nh       (fld_nx.nh),
        .code     (code_nx)
    );

    // next output state
    always_comb begin
        st_d.fld       = fld_nx;
        st_d.out_valid = in_valid && in_eop;
        st_d.out_code  = (in_valid && in_eop) ? code_nx : st_q.out_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_valid = st_q.out_valid;
    assign exc_code  = st_q.out_code;

    // strobe only follows an accepted end-of-packet byte
    p_strobe_after_eop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(in_valid && in_eop));

    p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_code <= 3'd6));

    // idle cycles leave all packet state untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.fld));

    // layer-3 byte count never shrinks inside a packet
    p_cnt_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop) |=> (st_q.fld.l3_cnt >= $past(st_q.fld.l3_cnt)));

    // a packet already known to be non-IP ends with code 1
    p_not_ip_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop && !in_sop && st_q.fld.kind == K_OTHER) |=> (exc_code == 3'd1));
endmodule

// File: tb/ipx_check_tb_top.sv
module ipx_check_tb_top;
    localparam int OFF_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_sop = 1'b0;
    logic             in_eop = 1'b0;
    logic [7:0]       in_data = '0;
    logic [OFF_W-1:0] l3_offset = '0;
    logic             exc_valid;
    logic [2:0]       exc_code;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    logic [7:0] pkt [0:255];
    int plen;
    int poff;

    always #2.5 clk = ~clk;

    ipx_check #(.OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .l3_offset(l3_offset),
        .exc_valid(exc_valid), .exc_code(exc_code)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_checks = n_checks + 1;
        if (got != exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // bench model of the verdict, written from the requirements
    function automatic int model();
        int n;
        int b0;
        int ihl;
        int hl;
        int s;
        int tot;
        int nh;
        n = (plen > poff) ? plen - poff : 0;
        if (n == 0) return 3;
        b0 = pkt[poff];
        if ((b0 >> 4) != 4 && (b0 >> 4) != 6) return 1;
        if ((b0 >> 4) == 4) begin
            ihl = b0 & 15;
            hl  = ihl * 4;
            if (ihl >= 5 && n >= hl) begin
                s = 0;
                for (int k = 0; k < hl; k += 2) s += {pkt[poff+k], pkt[poff+k+1]};
                s = (s & 16'hFFFF) + (s >> 16);
                s = (s & 16'hFFFF) + (s >> 16);
                if (s != 16'hFFFF) return 2;
            end
            if (ihl < 5 || n < hl) return 3;
            tot = {pkt[poff+2], pkt[poff+3]};
            if (n < tot) return 4;
            if (pkt[poff+8] == 0) return 5;
            if (ihl > 5) return 6;
            return 0;
        end
        if (n < 40) return 3;
        if (n < 40 + int'({pkt[poff+4], pkt[poff+5]})) return 4;
        if (pkt[poff+7] == 0) return 5;
        nh = pkt[poff+6];
        if (nh == 0 || nh == 43 || nh == 44 || nh == 60) return 6;
        return 0;
    endfunction

    task automatic fix_csum();
        int s;
        int hl;
        hl = (pkt[poff] & 15) * 4;
        pkt[poff+10] = 0;
        pkt[poff+11] = 0;
        s = 0;
        for (int k = 0; k < hl; k += 2) s += {pkt[poff+k], pkt[poff+k+1]};
        s = (s & 16'hFFFF) + (s >> 16);
        s = (s & 16'hFFFF) + (s >> 16);
        s = ~s & 16'hFFFF;
        pkt[poff+10] = s[15:8];
        pkt[poff+11] = s[7:0];
    endtask

    task automatic make_v4(input int off, input int ihl, input int pay);
        int tot;
        poff = off;
        tot  = ihl * 4 + pay;
        for (int k = 0; k < 256; k++) pkt[k] = 8'($urandom);
        pkt[off]   = 8'(8'h40 | ihl);
        pkt[off+2] = 8'(tot >> 8);
        pkt[off+3] = 8'(tot);
        pkt[off+8] = 8'(1 + $urandom % 255);
        plen = off + tot;
        fix_csum();
    endtask

    task automatic make_v6(input int off, input int pay, input int nh);
        poff = off;
        for (int k = 0; k < 256; k++) pkt[k] = 8'($urandom);
        pkt[off]   = 8'(8'h60 | ($urandom & 15));
        pkt[off+4] = 8'(pay >> 8);
        pkt[off+5] = 8'(pay);
        pkt[off+6] = 8'(nh);
        pkt[off+7] = 8'(1 + $urandom % 255);
        plen = off + 40 + pay;
    endtask

    // drive at falling edges; idle gaps carry junk that must be ignored (R9)
    task automatic send_and_check(input string tag, input int exp, input bit gaps);
        for (int k = 0; k < plen; k++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk);
                in_valid  = 1'b0;
                in_sop    = 1'($urandom);
                in_eop    = 1'($urandom);
                in_data   = 8'($urandom);
                l3_offset = OFF_W'($urandom);
            end
            @(negedge clk);
            in_valid  = 1'b1;
            in_sop    = (k == 0);
            in_eop    = (k == plen - 1);
            in_data   = pkt[k];
            l3_offset = (k == 0) ? OFF_W'(poff) : OFF_W'($urandom);
            if (k != plen - 1) check({tag, " R10 no early strobe"}, int'(exc_valid), 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        check({tag, " R10 strobe"}, int'(exc_valid), 1);
        check(tag, int'(exc_code), exp);
        @(negedge clk);
        check({tag, " R10 single strobe"}, int'(exc_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10 reset valid", int'(exc_valid), 0);
        check("R10 reset code", int'(exc_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 clean headers
        make_v4(0, 5, 10);
        send_and_check("R1 v4 clean", 0, 1'b0);
        make_v6(14, 8, 17);
        send_and_check("R1 v6 clean", 0, 1'b1);

        // R2 not IP overrides bad checksum and zero TTL
        make_v4(4, 5, 0);
        pkt[4] = 8'h55;
        pkt[12] = 8'h00;
        plen = 9;
        send_and_check("R2 version 5", 1, 1'b0);

        // R3 and R8: bad checksum beats zero TTL and options
        make_v4(2, 6, 4);
        pkt[2+8] = 8'h00;
        fix_csum();
        pkt[2+10] = pkt[2+10] ^ 8'h01;
        send_and_check("R3 R8 csum first", 2, 1'b0);

        // R3: checksum not judged on a truncated header
        make_v4(0, 5, 0);
        pkt[10] = pkt[10] ^ 8'hFF;
        plen = 19;
        send_and_check("R3 R4 truncated header", 3, 1'b0);

        // R4 boundary cases
        make_v4(0, 5, 0);
        plen = 20;
        send_and_check("R4 exact v4 header", 0, 1'b0);
        make_v4(0, 5, 0);
        pkt[0] = 8'h44;
        fix_csum();
        send_and_check("R4 IHL 4", 3, 1'b0);
        make_v4(12, 5, 0);
        plen = 12;
        send_and_check("R4 no layer-3 byte", 3, 1'b0);
        make_v6(0, 0, 6);
        plen = 39;
        send_and_check("R4 v6 39 bytes", 3, 1'b0);

        // R5 short payload, then trailing bytes accepted
        make_v4(0, 5, 8);
        plen = 27;
        send_and_check("R5 v4 one short", 4, 1'b0);
        make_v6(0, 5, 17);
        plen = plen + 3;
        send_and_check("R5 v6 trailer ok", 0, 1'b0);

        // R6
        make_v4(0, 5, 2);
        pkt[8] = 8'h00;
        fix_csum();
        send_and_check("R6 TTL zero", 5, 1'b0);
        make_v6(0, 0, 43);
        pkt[7] = 8'h00;
        send_and_check("R6 R8 hop zero over ext", 5, 1'b0);

        // R7
        make_v4(0, 6, 0);
        send_and_check("R7 v4 options", 6, 1'b0);
        make_v6(0, 0, 60);
        send_and_check("R7 v6 dest opts", 6, 1'b0);
        make_v6(0, 0, 59);
        send_and_check("R7 v6 no ext", 0, 1'b0);

        // R9 prefix that looks like another version
        make_v4(6, 5, 1);
        pkt[0] = 8'h60;
        pkt[5] = 8'h14;
        send_and_check("R9 prefix skipped", 0, 1'b1);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int sel;
            int exp;
            sel = $urandom % 3;
            if (sel == 0) begin
                make_v4($urandom % 16, 5 + $urandom % 3, $urandom % 20);
                if ($urandom % 5 == 0) begin pkt[poff+8] = 0; fix_csum(); end
                if ($urandom % 5 == 0) pkt[poff + $urandom % 20] ^= 8'(1 + $urandom % 255);
            end else if (sel == 1) begin
                int nhs [6] = '{0, 43, 44, 60, 6, 17};
                make_v6($urandom % 16, $urandom % 20, nhs[$urandom % 6]);
                if ($urandom % 5 == 0) pkt[poff+7] = 0;
            end else begin
                make_v4($urandom % 16, 5, $urandom % 8);
                pkt[poff] = 8'({4'($urandom % 16 == 4 ? 7 : $urandom % 16), 4'h5});
                if (pkt[poff][7:4] == 4'h6) pkt[poff] = 8'h15;
            end
            if ($urandom % 4 == 0) begin
                plen = $urandom % plen;
                if (plen == 0) plen = 1;
            end
            if ($urandom % 4 == 0) plen = plen + $urandom % 4;
            exp = model();
            send_and_check($sformatf("R8 random %0d", it), exp, 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule